// File: doc/BRIEF.md
# Multicycle Datapath Register Core

This block is the storage and arithmetic half of a 32-bit processor that runs each instruction over several clock cycles. An outside sequencer drives a set of control strobes every cycle. The datapath applies those strobes to one shared ALU, one unified memory port and a 32-entry register file. Holding registers keep values from one cycle to the next: the program counter, the instruction word, the memory read data, the two operands and the ALU result.

The block shows the sequencer the opcode field, the function field and the ALU zero flag. With these the sequencer can choose its next state. The datapath supports loads, stores, equality branches, absolute jumps and the basic register-to-register arithmetic.

Top module: `mc_datapath`

## Requirements
- R1: `mem_addr_o` shows the PC when `iord_i` is 0 and the registered ALU result when it is 1. `mem_wdata_o` shows the B operand register. `mem_rd_o` and `mem_wr_o` follow `mem_rd_i` and `mem_wr_i`.
- R2: The instruction register loads `mem_rdata_i` at a clock edge only when `ir_wr_i` is 1. Otherwise it holds its value. `opcode_o` is instruction bits 31:26 and `funct_o` is instruction bits 5:0.
- R3: The memory data, A, B and ALU-result registers load at every clock edge. A loads register[instr 25:21] and B loads register[instr 20:16].
- R4: A register write takes place at the edge when `reg_wr_i` is 1. The address is instr 15:11 when `reg_dst_i` is 1 and instr 20:16 when it is 0. The data is the registered ALU result when `mem_to_reg_i` is 0 and the memory data register when it is 1.
- R5: Register 0 always reads as zero. Writes to register 0 have no effect.
- R6: `alu_src_a_i` selects the first ALU operand: 0 gives the PC and 1 gives A. `alu_src_b_i` selects the second operand: 00 gives B, 01 gives 4, 10 gives the sign-extended instr 15:0, and 11 gives that value shifted left by 2.
- R7: `alu_op_i` 00 adds and 01 subtracts. `alu_op_i` 10 decodes `funct`: 0x20 is add, 0x22 is sub, 0x24 is and, 0x25 is or, and 0x2A is a signed set-less-than that returns 1 or 0. Any other funct value, and `alu_op_i` 11, add. `zero_o` is 1 when the live ALU result is 0.
- R8: `pc_src_i` selects the next PC: 00 gives the live ALU result, 01 gives the registered ALU result, and 10 gives {PC[31:28], instr[25:0], 2'b00}.
- R9: The PC loads at an edge when `pc_wr_i` is 1, or when both `pc_wr_cond_i` and `zero_o` are 1. Otherwise the PC holds its value.
- R10: While `rst_ni` is low, the PC, all holding registers and every register file entry clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_wr_i | input | 1 | Unconditional PC write |
| pc_wr_cond_i | input | 1 | PC write when the ALU result is zero |
| iord_i | input | 1 | Memory address select |
| mem_rd_i | input | 1 | Memory read strobe in |
| mem_wr_i | input | 1 | Memory write strobe in |
| ir_wr_i | input | 1 | Instruction register load |
| mem_to_reg_i | input | 1 | Register write data select |
| pc_src_i | input | 2 | Next PC select |
| alu_op_i | input | 2 | ALU operation class |
| alu_src_b_i | input | 2 | Second ALU operand select |
| alu_src_a_i | input | 1 | First ALU operand select |
| reg_wr_i | input | 1 | Register file write enable |
| reg_dst_i | input | 1 | Register write address select |
| mem_rdata_i | input | 32 | Memory read data |
| mem_addr_o | output | 32 | Memory address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rd_o | output | 1 | Memory read strobe out |
| mem_wr_o | output | 1 | Memory write strobe out |
| opcode_o | output | 6 | Instruction bits 31:26 |
| funct_o | output | 6 | Instruction bits 5:0 |
| zero_o | output | 1 | Live ALU result is zero |

## Verification
The bench builds the block with its default parameters: a 32-bit data width and 32 registers. At these values the set-less-than sign comparison and the 32-bit wrap of the PC arithmetic can be tested. A negative branch offset from PC 4 gives 0xFFFFFFFC, and a jump keeps the upper PC nibble 0xF. The full 5-bit register fields, including register 0, are also within reach. The bench drives every multi-cycle sequence by hand through the strobes. Register contents are read back only through the B operand on `mem_wdata_o`, and the ALU result only through `mem_addr_o`.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [2:0] {FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT} alu_fn_e;

  localparam logic [1:0] SRCB_REG  = 2'b00;
  localparam logic [1:0] SRCB_FOUR = 2'b01;
  localparam logic [1:0] SRCB_IMM  = 2'b10;
  localparam logic [1:0] SRCB_IMM4 = 2'b11;

  localparam logic [1:0] PCS_ALU = 2'b00;
  localparam logic [1:0] PCS_OUT = 2'b01;
  localparam logic [1:0] PCS_JMP = 2'b10;

  function automatic alu_fn_e alu_decode(logic [1:0] op, logic [5:0] funct);
    alu_fn_e fn;
    fn = FN_ADD;
    if (op == 2'b01) fn = FN_SUB;
    else if (op == 2'b10) begin
      case (funct)
        6'h22:   fn = FN_SUB;
        6'h24:   fn = FN_AND;
        6'h25:   fn = FN_OR;
        6'h2a:   fn = FN_SLT;
        default: fn = FN_ADD;
      endcase
    end
    return fn;
  endfunction
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] mem_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (we_i && waddr_i != '0) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // entry 0 is never written, so it stays at its reset value of 0
  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  alu_fn_e       fn_i,
  output logic [DW-1:0] res_o,
  output logic          zero_o
);
  always_comb begin
    case (fn_i)
      FN_SUB:  res_o = a_i - b_i;
      FN_AND:  res_o = a_i & b_i;
      FN_OR:   res_o = a_i | b_i;
      FN_SLT:  res_o = {{(DW-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: res_o = a_i + b_i;
    endcase
  end

  assign zero_o = (res_o == '0);
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pc_wr_i,
  input  logic          pc_wr_cond_i,
  input  logic          iord_i,
  input  logic          mem_rd_i,
  input  logic          mem_wr_i,
  input  logic          ir_wr_i,
  input  logic          mem_to_reg_i,
  input  logic [1:0]    pc_src_i,
  input  logic [1:0]    alu_op_i,
  input  logic [1:0]    alu_src_b_i,
  input  logic          alu_src_a_i,
  input  logic          reg_wr_i,
  input  logic          reg_dst_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [5:0]    opcode_o,
  output logic [5:0]    funct_o,
  output logic          zero_o
);
  localparam int AW = $clog2(NREG);

  logic [DW-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
  logic [DW-1:0] rf_a, rf_b, imm_sx, op_a, op_b, alu_res, pc_next, wr_data;
  logic [AW-1:0] wr_addr;
  logic          alu_zero, pc_en;
  alu_fn_e       alu_fn;

  assign imm_sx = {{(DW-16){ir_q[15]}}, ir_q[15:0]};

  always_comb begin
    op_a = alu_src_a_i ? a_q : pc_q;
    case (alu_src_b_i)
      SRCB_REG:  op_b = b_q;
      SRCB_FOUR: op_b = DW'(4);
      SRCB_IMM:  op_b = imm_sx;
      default:   op_b = imm_sx << 2;
    endcase
    case (pc_src_i)
      PCS_OUT: pc_next = aluout_q;
      PCS_JMP: pc_next = {pc_q[DW-1:DW-4], ir_q[25:0], 2'b00};
      default: pc_next = alu_res;
    endcase
  end

  assign alu_fn  = alu_decode(alu_op_i, ir_q[5:0]);
  assign pc_en   = pc_wr_i | (pc_wr_cond_i & alu_zero);
  assign wr_addr = reg_dst_i ? ir_q[11+AW-1:11] : ir_q[16+AW-1:16];
  assign wr_data = mem_to_reg_i ? mdr_q : aluout_q;

  mc_alu #(.DW(DW)) u_alu (
    .a_i   (op_a),
    .b_i   (op_b),
    .fn_i  (alu_fn),
    .res_o (alu_res),
    .zero_o(alu_zero)
  );

  mc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_wr_i),
    .waddr_i  (wr_addr),
    .wdata_i  (wr_data),
    .raddr_a_i(ir_q[21+AW-1:21]),
    .raddr_b_i(ir_q[16+AW-1:16]),
    .rdata_a_o(rf_a),
    .rdata_b_o(rf_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      ir_q     <= '0;
      mdr_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
    end else begin
      if (pc_en)   pc_q <= pc_next;
      if (ir_wr_i) ir_q <= mem_rdata_i;
      // these four carry values only into the next cycle, so they load every edge
      mdr_q    <= mem_rdata_i;
      a_q      <= rf_a;
      b_q      <= rf_b;
      aluout_q <= alu_res;
    end
  end

  assign mem_addr_o  = iord_i ? aluout_q : pc_q;
  assign mem_wdata_o = b_q;
  assign mem_rd_o    = mem_rd_i;
  assign mem_wr_o    = mem_wr_i;
  assign opcode_o    = ir_q[31:26];
  assign funct_o     = ir_q[5:0];
  assign zero_o      = alu_zero;
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ir_wr_i,
  input logic          pc_wr_i,
  input logic          pc_wr_cond_i,
  input logic [1:0]    pc_src_i,
  input logic [DW-1:0] mem_rdata_i,
  input logic          zero_o,
  input logic [DW-1:0] pc_q,
  input logic [DW-1:0] ir_q,
  input logic [DW-1:0] mdr_q,
  input logic [DW-1:0] a_q
);
  assert_ir_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ir_wr_i |=> $stable(ir_q));

  assert_ir_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_wr_i |=> ir_q == $past(mem_rdata_i));

  assert_mdr_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> mdr_q == $past(mem_rdata_i));

  assert_reg0_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_q[25:21] == 5'd0 |=> a_q == '0);

  assert_jump_target_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_wr_i && pc_src_i == 2'b10) |=>
      (pc_q[1:0] == 2'b00 && pc_q[DW-1:DW-4] == $past(pc_q[DW-1:DW-4])));

  assert_pc_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pc_wr_i && !pc_wr_cond_i) |=> $stable(pc_q));

  assert_pc_cond_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pc_wr_i && pc_wr_cond_i && !zero_o) |=> $stable(pc_q));
endmodule

bind mc_datapath mc_datapath_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ir_wr_i     (ir_wr_i),
  .pc_wr_i     (pc_wr_i),
  .pc_wr_cond_i(pc_wr_cond_i),
  .pc_src_i    (pc_src_i),
  .mem_rdata_i (mem_rdata_i),
  .zero_o      (zero_o),
  .pc_q        (pc_q),
  .ir_q        (ir_q),
  .mdr_q       (mdr_q),
  .a_q         (a_q)
);

// File: tb/sim_mc_datapath.sv
`timescale 1ns/100ps
module sim_mc_datapath;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pc_wr, pc_wr_cond, iord, mem_rd, mem_wr, ir_wr, mem_to_reg;
  logic [1:0] pc_src, alu_op, alu_src_b;
  logic alu_src_a, reg_wr, reg_dst;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic mem_rd_o, mem_wr_o, zero;
  logic [5:0] opcode, funct;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mc_datapath u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pc_wr_i(pc_wr), .pc_wr_cond_i(pc_wr_cond),
    .iord_i(iord), .mem_rd_i(mem_rd), .mem_wr_i(mem_wr), .ir_wr_i(ir_wr),
    .mem_to_reg_i(mem_to_reg), .pc_src_i(pc_src), .alu_op_i(alu_op),
    .alu_src_b_i(alu_src_b), .alu_src_a_i(alu_src_a), .reg_wr_i(reg_wr),
    .reg_dst_i(reg_dst), .mem_rdata_i(mem_rdata), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .opcode_o(opcode), .funct_o(funct), .zero_o(zero)
  );

  // R-type table: funct, operand A, operand B, expected result
  localparam int NV = 7;
  localparam logic [5:0]  T_FN [NV] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2a, 6'h2a, 6'h22};
  localparam logic [31:0] T_A  [NV] = '{32'd5, 32'd3, 32'hF0F0FFFF, 32'h12000000,
                                        32'hFFFFFFFB, 32'd3, 32'd9};
  localparam logic [31:0] T_B  [NV] = '{32'd7, 32'd10, 32'h0FF01234, 32'h00000034,
                                        32'd3, 32'hFFFFFFFB, 32'd9};
  localparam logic [31:0] T_R  [NV] = '{32'd12, 32'hFFFFFFF9, 32'h00F01234, 32'h12000034,
                                        32'd1, 32'd0, 32'd0};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    {pc_wr, pc_wr_cond, iord, mem_rd, mem_wr, ir_wr, mem_to_reg} = '0;
    {pc_src, alu_op, alu_src_b, alu_src_a, reg_wr, reg_dst} = '0;
  endtask

  task automatic fetch(input logic [31:0] instr);
    idle();
    ir_wr = 1'b1; mem_rdata = instr;
    tick();
    ir_wr = 1'b0;
  endtask

  // load-word style write: IR names rt, MDR carries the value, MemtoReg=1 RegDst=0
  task automatic load_reg(input logic [4:0] r, input logic [31:0] v);
    fetch({6'h23, 5'd0, r, 16'h0});
    mem_rdata = v;
    tick();
    reg_wr = 1'b1; mem_to_reg = 1'b1; reg_dst = 1'b0;
    tick();
    idle();
  endtask

  // register contents come out on mem_wdata_o through B, one edge after IR
  task automatic read_reg(input logic [4:0] r, input logic [31:0] exp, input string tag);
    fetch({6'h00, 5'd0, r, 16'h0});
    tick();
    chk(tag, mem_wdata, exp);
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    mem_rdata = '0;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10 pc after reset", mem_addr, 32'h0);
    chk("R10 B after reset", mem_wdata, 32'h0);
    chk("R10 ir after reset", {20'h0, opcode, funct}, 32'h0);
    rst_ni = 1'b1;
    tick();

    // R6/R8/R9: PC + 4 through the live ALU result
    alu_src_a = 1'b0; alu_src_b = 2'b01; alu_op = 2'b00; pc_src = 2'b00; pc_wr = 1'b1;
    tick();
    idle(); #1;
    chk("R9 pc increment", mem_addr, 32'd4);

    // R2: IR holds when not enabled
    fetch({6'h23, 20'h0, 6'h15});
    mem_rdata = 32'hFFFFFFFF;
    tick();
    chk("R2 opcode hold", {26'h0, opcode}, 32'h23);
    chk("R2 funct hold", {26'h0, funct}, 32'h15);

    // R7/R4/R3: table of R-type operations with write-back to r3 and readback
    for (int i = 0; i < NV; i++) begin
      load_reg(5'd1, T_A[i]);
      load_reg(5'd2, T_B[i]);
      fetch({6'h00, 5'd1, 5'd2, 5'd3, 5'd0, T_FN[i]});
      tick();
      alu_src_a = 1'b1; alu_src_b = 2'b00; alu_op = 2'b10;
      #1;
      chk($sformatf("R7 zero flag vec%0d", i), {31'h0, zero}, {31'h0, T_R[i] == 32'h0});
      tick();
      iord = 1'b1; #1;
      chk($sformatf("R1 aluout on addr vec%0d", i), mem_addr, T_R[i]);
      reg_wr = 1'b1; reg_dst = 1'b1; mem_to_reg = 1'b0;
      tick();
      idle();
      read_reg(5'd3, T_R[i], $sformatf("R4 writeback vec%0d", i));
    end

    // R5: register 0 ignores writes
    load_reg(5'd0, 32'hDEAD0001);
    read_reg(5'd0, 32'h0, "R5 reg0 stays zero");

    // R9: PC untouched by all the above
    #1;
    chk("R9 pc held", mem_addr, 32'd4);

    // R9/R6/R8: branch, not taken then taken; offset -2 words
    load_reg(5'd4, 32'h55);
    load_reg(5'd5, 32'h56);
    fetch({6'h04, 5'd4, 5'd5, 16'hFFFE});
    alu_src_a = 1'b0; alu_src_b = 2'b11; alu_op = 2'b00;
    tick();
    alu_src_a = 1'b1; alu_src_b = 2'b00; alu_op = 2'b01; pc_wr_cond = 1'b1; pc_src = 2'b01;
    tick();
    idle(); #1;
    chk("R9 branch not taken", mem_addr, 32'd4);

    load_reg(5'd5, 32'h55);
    fetch({6'h04, 5'd4, 5'd5, 16'hFFFE});
    alu_src_a = 1'b0; alu_src_b = 2'b11; alu_op = 2'b00;
    tick();
    alu_src_a = 1'b1; alu_src_b = 2'b00; alu_op = 2'b01; pc_wr_cond = 1'b1; pc_src = 2'b01;
    #1;
    chk("R7 zero on equal", {31'h0, zero}, 32'h1);
    tick();
    idle(); #1;
    chk("R8 branch taken", mem_addr, 32'hFFFFFFFC);

    // R8: jump keeps PC[31:28]
    fetch({6'h02, 26'h0000040});
    pc_wr = 1'b1; pc_src = 2'b10;
    tick();
    idle(); #1;
    chk("R8 jump target", mem_addr, 32'hF0000100);

    // R6/R1: address from A plus negative offset; store data and strobes
    load_reg(5'd6, 32'h1000);
    load_reg(5'd7, 32'hCAFEBABE);
    fetch({6'h2b, 5'd6, 5'd7, 16'hFFF0});
    tick();
    alu_src_a = 1'b1; alu_src_b = 2'b10; alu_op = 2'b00;
    tick();
    iord = 1'b1; mem_wr = 1'b1; #1;
    chk("R6 offset address", mem_addr, 32'h00000FF0);
    chk("R1 store data", mem_wdata, 32'hCAFEBABE);
    chk("R1 strobes", {30'h0, mem_rd_o, mem_wr_o}, 32'h1);
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule